// File: doc/BRIEF.md
# Timer Event Flag and Interrupt Enable Registers

This block holds the event status and interrupt masking for a 16-bit timer. Two 8-bit registers sit on a simple register bus. The status register keeps one sticky flag for counter wrap-around and one flag for each capture/compare channel. The enable register keeps one mask bit per flag. One-cycle pulses from the timer core set the flags. Each interrupt line is a level equal to its flag ANDed with its mask bit.

Software clears a flag with a handshake. It first reads the status register while the flag is 1, which arms that flag. It then writes 0 to the flag's bit position. A write of 0 to a flag that has not been armed does nothing. This stops a read-modify-write from wiping out an event that arrived after the read.

The counter and the capture/compare datapaths are outside the block. They only deliver pulses on `ovf_evt` and `cmp_evt`. Read data depends only on `addr`. With `RD_LATENCY` = 0 it is combinational; with 1 it is registered.

Top module: `tmr_irq_regs`

## Requirements
- R1: After reset, both registers read 0x70 and every interrupt output is 0.
- R2: A one-cycle pulse on `ovf_evt` sets status bit 7. A pulse on `cmp_evt[n]` sets status bit n (channel A is bit 0, channel D is bit 3). Each flag reads 1 from the next cycle on.
- R3: A write of 0 to a set flag that was not read as 1 since it was last armed or cleared leaves the flag at 1.
- R4: A status read that returns a flag as 1, followed by a status write with 0 in that bit, clears that flag. Flags written as 1 in the same write stay as they are.
- R5: Writing 1 to any flag bit of the status register never changes it, and it does not cancel an earlier arming.
- R6: If an event pulse and an armed write of 0 hit the same flag in the same cycle, the flag stays 1 and its arming is dropped. A further write of 0 without a new read leaves it at 1.
- R7: The enable register (address 1) stores bits 7 and 3 to 0 as written. Its bits 6 to 4 always read 1.
- R8: Each interrupt output equals its flag ANDed with its enable bit. A masked flag still sets and reads back as 1.
- R9: An asserted interrupt output stays asserted until its flag is cleared or its enable bit is written to 0.
- R10: Bits 6 to 4 of the status register (address 0) ignore writes and always read 1.
- R11: A status read that sees a flag at 0 does not arm it. If the flag then sets and is written 0 without a new read, it stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W (1) | Register select: 0 status, 1 enable |
| rd_en | input | 1 | Read strobe; a status read arms flags seen at 1 |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| ovf_evt | input | 1 | One-cycle counter wrap pulse |
| cmp_evt | input | NUM_CMP (4) | One-cycle capture/compare pulses, bit 0 = channel A |
| ovf_irq | output | 1 | Overflow interrupt request level |
| cmp_irq | output | NUM_CMP (4) | Channel interrupt request levels |

## Verification
A hardware event pulse and a software clear can land on the same flag in the same cycle. The bench arms a channel flag with a status read. It then drives, in one clock, a status write of 0 to that bit together with a new pulse on that channel. It judges the outcome by reading the status back: the flag must still be 1. A second write of 0 with no read in between must also leave it at 1, which shows the arming was dropped.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

   localparam int REG_W   = 8;
   localparam int OVF_POS = 7;
   localparam int MAX_CMP = 4;

   // bits between the last channel and the overflow bit read back as 1
   function automatic logic [REG_W-1:0] fill_mask(input int ncmp);
      logic [REG_W-1:0] m;
      m = '0;
      for (int b = 0; b < OVF_POS; b++) begin
         if (b >= ncmp) m[b] = 1'b1;
      end
      return m;
   endfunction

   function automatic logic [REG_W-1:0] pack_reg(input logic ovf,
                                                 input logic [MAX_CMP-1:0] chan,
                                                 input int ncmp);
      logic [REG_W-1:0] v;
      v = fill_mask(ncmp);
      v[OVF_POS] = ovf;
      for (int b = 0; b < MAX_CMP; b++) begin
         if (b < ncmp) v[b] = chan[b];
      end
      return v;
   endfunction

endpackage

// File: rtl/tmr_irq_flag.sv
module tmr_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic rd_hit_i,
   input  logic wr_hit_i,
   input  logic wbit_i,
   output logic flag_o
);

   logic flag_q, armed_q;
   logic clr_req;

   assign clr_req = wr_hit_i && !wbit_i && armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (set_i) begin
            flag_q <= 1'b1;
            if (clr_req) armed_q <= 1'b0;
            else if (rd_hit_i && flag_q) armed_q <= 1'b1;
         end else if (clr_req) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
         end else if (rd_hit_i && flag_q) begin
            armed_q <= 1'b1;
         end
      end
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/tmr_irq_enable.sv
module tmr_irq_enable #(
   parameter int NUM_CMP = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_hit_i,
   input  logic [7:0]         wdata_i,
   output logic               ovf_en_o,
   output logic [NUM_CMP-1:0] cmp_en_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_en_o <= 1'b0;
         cmp_en_o <= '0;
      end else if (wr_hit_i) begin
         ovf_en_o <= wdata_i[tmr_irq_pkg::OVF_POS];
         cmp_en_o <= wdata_i[NUM_CMP-1:0];
      end
   end

endmodule

// File: rtl/tmr_irq_rdmux.sv
module tmr_irq_rdmux #(
   parameter int          RD_LATENCY = 0,
   parameter logic [7:0]  IDLE_VAL   = 8'h70
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel_en_i,
   input  logic [7:0] stat_i,
   input  logic [7:0] en_i,
   output logic [7:0] rdata_o
);

   logic [7:0] mux_val;
   assign mux_val = sel_en_i ? en_i : stat_i;

   generate
      if (RD_LATENCY == 0) begin : g_comb
         assign rdata_o = mux_val;
      end else begin : g_reg
         logic [7:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= IDLE_VAL;
            else        rd_q <= mux_val;
         end
         assign rdata_o = rd_q;
      end
   endgenerate

endmodule

// File: rtl/tmr_irq_regs.sv
module tmr_irq_regs #(
   parameter int ADDR_W     = 1,
   parameter int NUM_CMP    = 4,
   parameter int STAT_ADDR  = 0,
   parameter int EN_ADDR    = 1,
   parameter int RD_LATENCY = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               rd_en,
   input  logic               wr_en,
   input  logic [7:0]         wdata,
   output logic [7:0]         rdata,
   input  logic               ovf_evt,
   input  logic [NUM_CMP-1:0] cmp_evt,
   output logic               ovf_irq,
   output logic [NUM_CMP-1:0] cmp_irq
);

   import tmr_irq_pkg::*;

   localparam int         NUM_FLAGS = NUM_CMP + 1;
   localparam logic [7:0] RST_VAL   = fill_mask(NUM_CMP);

   generate
      if (NUM_CMP < 1 || NUM_CMP > MAX_CMP) begin : g_bad_cmp
         $error("tmr_irq_regs: NUM_CMP must be 1..4");
      end
      if (STAT_ADDR == EN_ADDR) begin : g_bad_addr
         $error("tmr_irq_regs: register addresses must differ");
      end
      if (RD_LATENCY != 0 && RD_LATENCY != 1) begin : g_bad_lat
         $error("tmr_irq_regs: RD_LATENCY must be 0 or 1");
      end
   endgenerate

   logic stat_sel, en_sel;
   logic stat_rd, stat_wr, en_wr;

   assign stat_sel = (addr == ADDR_W'(STAT_ADDR));
   assign en_sel   = (addr == ADDR_W'(EN_ADDR));
   assign stat_rd  = rd_en && stat_sel;
   assign stat_wr  = wr_en && stat_sel;
   assign en_wr    = wr_en && en_sel;

   // index NUM_CMP is the overflow flag, the rest are channels
   logic [NUM_FLAGS-1:0] evt_vec, wbit_vec, flag_vec, en_vec;

   assign evt_vec  = {ovf_evt, cmp_evt};
   assign wbit_vec = {wdata[OVF_POS], wdata[NUM_CMP-1:0]};

   genvar gi;
   generate
      for (gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
         tmr_irq_flag u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (evt_vec[gi]),
            .rd_hit_i (stat_rd),
            .wr_hit_i (stat_wr),
            .wbit_i   (wbit_vec[gi]),
            .flag_o   (flag_vec[gi])
         );
      end
   endgenerate

   logic               ovf_en;
   logic [NUM_CMP-1:0] cmp_en;

   tmr_irq_enable #(.NUM_CMP(NUM_CMP)) u_enable (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit_i (en_wr),
      .wdata_i  (wdata),
      .ovf_en_o (ovf_en),
      .cmp_en_o (cmp_en)
   );

   assign en_vec = {ovf_en, cmp_en};

   logic [MAX_CMP-1:0] flag_pad, en_pad;
   logic [7:0]         stat_byte, en_byte;

   always_comb begin
      flag_pad = '0;
      en_pad   = '0;
      flag_pad[NUM_CMP-1:0] = flag_vec[NUM_CMP-1:0];
      en_pad[NUM_CMP-1:0]   = cmp_en;
      stat_byte = pack_reg(flag_vec[NUM_CMP], flag_pad, NUM_CMP);
      en_byte   = pack_reg(ovf_en, en_pad, NUM_CMP);
   end

   tmr_irq_rdmux #(.RD_LATENCY(RD_LATENCY), .IDLE_VAL(RST_VAL)) u_rdmux (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_en_i (en_sel),
      .stat_i   (stat_byte),
      .en_i     (en_byte),
      .rdata_o  (rdata)
   );

   logic [NUM_FLAGS-1:0] irq_vec;
   assign irq_vec = flag_vec & en_vec;
   assign ovf_irq = irq_vec[NUM_CMP];
   assign cmp_irq = irq_vec[NUM_CMP-1:0];

endmodule

// File: rtl/tmr_irq_regs_chk.sv
module tmr_irq_regs_chk #(
   parameter int ADDR_W    = 1,
   parameter int NUM_CMP   = 4,
   parameter int STAT_ADDR = 0
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  addr,
   input logic               wr_en,
   input logic [7:0]         wdata,
   input logic [7:0]         rdata,
   input logic               ovf_evt,
   input logic [NUM_CMP-1:0] cmp_evt,
   input logic               ovf_irq,
   input logic [NUM_CMP-1:0] cmp_irq,
   input logic [NUM_CMP:0]   flags
);

   logic            stat_wr;
   logic [NUM_CMP:0] evt, irq, wbit;

   assign stat_wr = wr_en && (addr == ADDR_W'(STAT_ADDR));
   assign evt     = {ovf_evt, cmp_evt};
   assign irq     = {ovf_irq, cmp_irq};
   assign wbit    = {wdata[7], wdata[NUM_CMP-1:0]};

   // R10 / R7: reserved positions read 1 whatever is addressed
   p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[6:NUM_CMP] == '1);

   genvar gi;
   generate
      for (gi = 0; gi <= NUM_CMP; gi++) begin : g_f
         p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
            evt[gi] |=> flags[gi]);
         p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[gi] && stat_wr && !wbit[gi]) |=> flags[gi]);
         p_clear_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[gi]) |-> $past(stat_wr && !wbit[gi]));
         p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[gi] && !wr_en) |=> irq[gi]);
         p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq[gi] |-> flags[gi]);
      end
   endgenerate

endmodule

bind tmr_irq_regs tmr_irq_regs_chk #(
   .ADDR_W(ADDR_W), .NUM_CMP(NUM_CMP), .STAT_ADDR(STAT_ADDR)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .addr    (addr),
   .wr_en   (wr_en),
   .wdata   (wdata),
   .rdata   (rdata),
   .ovf_evt (ovf_evt),
   .cmp_evt (cmp_evt),
   .ovf_irq (ovf_irq),
   .cmp_irq (cmp_irq),
   .flags   (flag_vec)
);

// File: tb/tmr_irq_regs_bench.sv
module tmr_irq_regs_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [0:0] addr = '0;
   logic       rd_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       ovf_evt = 1'b0;
   logic [3:0] cmp_evt = '0;
   logic       ovf_irq;
   logic [3:0] cmp_irq;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] rd_cap;

   localparam logic [0:0] ST = 1'b0;
   localparam logic [0:0] EN = 1'b1;

   always #2 clk = ~clk;

   tmr_irq_regs u_tmr_irq_regs (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
      .wdata(wdata), .rdata(rdata), .ovf_evt(ovf_evt), .cmp_evt(cmp_evt),
      .ovf_irq(ovf_irq), .cmp_irq(cmp_irq)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
      end
   endtask

   // one clock of bus/event activity, started and ended at a falling edge
   task automatic step(input logic rd, input logic wr, input logic [0:0] a,
                       input logic [7:0] d, input logic ov, input logic [3:0] c);
      rd_en = rd; wr_en = wr; addr = a; wdata = d; ovf_evt = ov; cmp_evt = c;
      #1 rd_cap = rdata;
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0; ovf_evt = 1'b0; cmp_evt = '0; addr = ST;
   endtask

   task automatic rd(input logic [0:0] a);
      step(1'b1, 1'b0, a, 8'h00, 1'b0, 4'h0);
   endtask

   task automatic wr(input logic [0:0] a, input logic [7:0] d);
      step(1'b0, 1'b1, a, d, 1'b0, 4'h0);
   endtask

   task automatic evt(input logic ov, input logic [3:0] c);
      step(1'b0, 1'b0, ST, 8'h00, ov, c);
   endtask

   task automatic irq_val(output logic [7:0] v);
      v = {ovf_irq, 3'b000, cmp_irq};
   endtask

   task automatic clear_all();
      rd(ST); wr(ST, 8'h00); wr(EN, 8'h00);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(ST); chk("R1 status after reset", rd_cap, 8'h70);
      rd(EN); chk("R1 enable after reset", rd_cap, 8'h70);
      irq_val(v); chk("R1 irqs after reset", v, 8'h00);
   endtask

   task automatic t_set();
      evt(1'b1, 4'h0); rd(ST); chk("R2 overflow sets bit7", rd_cap, 8'hF0);
      evt(1'b0, 4'h4); rd(ST); chk("R2 channel C sets bit2", rd_cap, 8'hF4);
      evt(1'b0, 4'h9); rd(ST); chk("R2 channels A,D set bits 0,3", rd_cap, 8'hFD);
      wr(ST, 8'h00); rd(ST); chk("R4 full clear after read", rd_cap, 8'h70);
   endtask

   task automatic t_no_arm();
      evt(1'b0, 4'h1);
      wr(ST, 8'h00); rd(ST); chk("R3 write 0 without read keeps flag", rd_cap, 8'h71);
      wr(ST, 8'hFE); rd(ST); chk("R4 clear after read", rd_cap, 8'h70);
   endtask

   task automatic t_partial();
      evt(1'b0, 4'h3); rd(ST); chk("R2 A and B set", rd_cap, 8'h73);
      wr(ST, 8'hFE); rd(ST); chk("R4/R5 only A cleared, B written 1 kept", rd_cap, 8'h72);
      wr(ST, 8'hFD); rd(ST); chk("R5 write 1 kept B armed, now cleared", rd_cap, 8'h70);
   endtask

   task automatic t_collision();
      evt(1'b0, 4'h4); rd(ST);
      step(1'b0, 1'b1, ST, 8'h00, 1'b0, 4'h4);
      rd(ST); chk("R6 set wins over clear", rd_cap, 8'h74);
      clear_pending_check();
   endtask

   task automatic clear_pending_check();
      // the read above re-armed; a fresh unarmed test needs no read in between
      wr(ST, 8'h00); rd(ST); chk("R4 clear after collision read", rd_cap, 8'h70);
      evt(1'b0, 4'h4); rd(ST);
      step(1'b0, 1'b1, ST, 8'h00, 1'b0, 4'h4);
      wr(ST, 8'h00);
      rd(ST); chk("R6 arming dropped after collision", rd_cap, 8'h74);
      wr(ST, 8'h00); rd(ST); chk("R4 clear after re-read", rd_cap, 8'h70);
   endtask

   task automatic t_enable();
      wr(EN, 8'hFF); rd(EN); chk("R7 enable all", rd_cap, 8'hFF);
      wr(EN, 8'h00); rd(EN); chk("R7 enable none, reserved 1", rd_cap, 8'h70);
      wr(EN, 8'h85); rd(EN); chk("R7 enable pattern", rd_cap, 8'hF5);
      rd(ST); chk("R7 enable write leaves status", rd_cap, 8'h70);
   endtask

   task automatic t_irq();
      logic [7:0] v;
      wr(EN, 8'h81);
      evt(1'b1, 4'h3);
      irq_val(v); chk("R8 irq = flag & enable", v, 8'h81);
      rd(ST); chk("R8 masked flag B still set", rd_cap, 8'hF3);
      repeat (5) @(negedge clk);
      irq_val(v); chk("R9 irq held while flags stay", v, 8'h81);
      wr(EN, 8'h80);
      irq_val(v); chk("R9 enable removal drops A irq", v, 8'h80);
      rd(ST); wr(ST, 8'h7F);
      irq_val(v); chk("R9 overflow clear drops irq", v, 8'h00);
      rd(ST); chk("R4 channel flags kept", rd_cap, 8'h73);
      clear_all();
   endtask

   task automatic t_reserved();
      wr(ST, 8'h8F); rd(ST); chk("R10 status ignores 1s and reserved", rd_cap, 8'h70);
      wr(ST, 8'h00); rd(ST); chk("R10 reserved still read 1", rd_cap, 8'h70);
   endtask

   task automatic t_read_zero();
      rd(ST);
      evt(1'b0, 4'h1);
      wr(ST, 8'h00); rd(ST); chk("R11 read at 0 did not arm", rd_cap, 8'h71);
      wr(ST, 8'h00); rd(ST); chk("R4 clear after proper read", rd_cap, 8'h70);
   endtask

   bit done = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set();
      t_no_arm();
      t_partial();
      t_collision();
      t_enable();
      clear_all();
      t_irq();
      t_reserved();
      t_read_zero();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule